// File: doc/BRIEF.md
# Drive Data Bus Read Receiver

This block sits at the controller end of a read transfer from a storage drive. Another path issues the read command. Once that path reports the command accepted (`cmd_go`), the block waits for the drive to report occupied. It then raises `run_o`, which asks the drive to start streaming. The drive sends each data word with a parity bit and marks it with a strobe pulse. The block synchronises the strobe. It latches the word and parity when it sees the strobe fall, checks odd parity, and presents the word on a valid/ready stream together with an error flag.

When the drive marks the end of a block, the block uses the `more_i` level to decide whether `run_o` stays high for another block without releasing the bus. If no more blocks are wanted, `run_o` drops. When the end-of-block line falls while `run_o` is low, the transfer is over: a one-cycle interrupt fires and the block becomes idle again. Two things set a sticky timeout flag and end the attempt: the drive never reporting occupied, or the drive going silent during the transfer.

The output stream follows these back-pressure rules. `m_valid` rises on a captured word. It stays high, with `m_data` and `m_perr` frozen, until a cycle with `m_ready` high. The drive cannot be stalled. A word that arrives while the previous word is still waiting is discarded and sets `m_ovf`. A fresh command clears `m_ovf` and `tmo_o`.

Top module: `drv_rd_rx`

## Requirements
- R1: After reset, `run_o`, `m_valid`, `m_ovf`, `tmo_o` and `eot_irq` are all low.
- R2: After `cmd_go` in the idle state, `run_o` stays low until `occ_i` is high. `run_o` rises no more than 4 cycles after `occ_i` rises, which is far inside the 100 µs limit. `cmd_go` outside the idle state is ignored.
- R3: A word is captured only on a falling strobe (`sclk_i` high then low) while the transfer is running. A rising strobe, or a strobe pulse while idle, produces no output word.
- R4: Parity is odd: a word is good when `m_data` together with its parity bit holds an odd number of ones. `m_perr` is high with any word for which this is false.
- R5: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_perr` hold. A cycle with both high consumes the word.
- R6: A capture while `m_valid` is high and `m_ready` is low discards the new word, keeps the held word, and sets `m_ovf`. `m_ovf` stays set until the next accepted `cmd_go`.
- R7: If `more_i` is high, `run_o` stays high across an end-of-block, no interrupt fires when `ebl_i` falls, and the words of the next block are delivered.
- R8: If `more_i` is low when `ebl_i` rises, `run_o` falls no more than 4 cycles after `ebl_i` rises, within the 500 ns deadline.
- R9: If `more_i` goes low during a block, `run_o` falls before `ebl_i` arrives. The remaining words are still delivered, and `tmo_o` stays low.
- R10: A fall of `ebl_i` after `run_o` is low gives exactly one cycle of `eot_irq` and returns the block to idle, where a new `cmd_go` is accepted.
- R11: If no occupied report, no word and no end-of-block edge is seen for `TMO_CYC` cycles while a transfer is pending, `tmo_o` is set and `run_o` is low. `tmo_o` does not rise before `TMO_CYC` cycles have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | Read command accepted pulse |
| occ_i | input | 1 | Drive occupied (asynchronous) |
| sclk_i | input | 1 | Drive word strobe (asynchronous) |
| ebl_i | input | 1 | Drive end-of-block (asynchronous) |
| dat_i | input | DW | Drive data lines |
| par_i | input | 1 | Drive parity line |
| more_i | input | 1 | High to keep reading further blocks |
| run_o | output | 1 | Run request to the drive |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Output word accepted |
| m_data | output | DW | Output word |
| m_perr | output | 1 | Parity error for the output word |
| m_ovf | output | 1 | Sticky overflow flag |
| tmo_o | output | 1 | Sticky timeout flag |
| eot_irq | output | 1 | End-of-transfer pulse |

## Verification
The bench drives strobe pulses whose data changes at the rise. A design that latched on the rising edge would therefore deliver stale or wrong words, and a design that did not gate capture would deliver a word after a pulse sent while idle. Words with flipped parity check the error flag. A design using even parity, or one that failed to keep the error flag with its word, would flag the wrong words. Holding `m_ready` low over two strobes checks that the first word is kept and the overflow flag sets, so a design that overwrote the held word would be caught. Further scenarios cover a multi-block run where `run_o` must not drop, an early drop before end-of-block, and both timeout paths, including a check that the timeout does not fire early.

// File: rtl/drv_rd_pkg.sv
package drv_rd_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WOCC = 2'd1,
    XS_LIVE = 2'd2,
    XS_TAIL = 2'd3
  } xfer_st_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/rd_capture.sv
module rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          strobe_fall,
  input  logic [DW-1:0] dat_i,
  input  logic          par_i,
  input  logic          clr,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  output logic          m_perr,
  output logic          m_ovf
);
  logic take, blocked;
  assign take    = cap_en && strobe_fall;
  assign blocked = m_valid && !m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_perr  <= 1'b0;
      m_ovf   <= 1'b0;
    end else begin
      if (clr) m_ovf <= 1'b0;
      if (take && blocked) begin
        m_ovf <= 1'b1;
      end else if (take) begin
        m_valid <= 1'b1;
        m_data  <= dat_i;
        m_perr  <= ~(^{dat_i, par_i});
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  // R5
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_perr)));
  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_ovf) |-> $past(m_valid && !m_ready));
endmodule

// File: rtl/xfer_ctl.sv
module xfer_ctl
  import drv_rd_pkg::*;
#(
  parameter int TMO_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_go,
  input  logic occ_s,
  input  logic ebl_rise,
  input  logic ebl_fall,
  input  logic word_seen,
  input  logic more_i,
  output logic run_o,
  output logic cap_en,
  output logic clr,
  output logic eot_irq,
  output logic tmo_o
);
  localparam int CW = $clog2(TMO_CYC + 1);

  xfer_st_e st, st_nx;
  logic [CW-1:0] wait_cnt;
  logic expire, activity;

  assign activity = word_seen || ebl_rise || ebl_fall;
  assign expire   = (st != XS_IDLE) && !activity &&
                    (wait_cnt == CW'(TMO_CYC - 1));
  assign clr      = (st == XS_IDLE) && cmd_go;

  always_comb begin
    st_nx = st;
    unique case (st)
      XS_IDLE: if (cmd_go)  st_nx = XS_WOCC;
      XS_WOCC: if (occ_s)   st_nx = XS_LIVE;
      XS_LIVE: if (!more_i) st_nx = XS_TAIL;
      XS_TAIL: if (ebl_fall) st_nx = XS_IDLE;
      default: st_nx = XS_IDLE;
    endcase
    if (expire) st_nx = XS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= XS_IDLE;
      wait_cnt <= '0;
      tmo_o    <= 1'b0;
      eot_irq  <= 1'b0;
    end else begin
      st      <= st_nx;
      eot_irq <= (st == XS_TAIL) && ebl_fall && !expire;
      if (clr)         tmo_o <= 1'b0;
      else if (expire) tmo_o <= 1'b1;
      if (st_nx != st || activity || st == XS_IDLE) wait_cnt <= '0;
      else                                          wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assign run_o  = (st == XS_LIVE);
  assign cap_en = (st == XS_LIVE) || (st == XS_TAIL);

  // R2
  run_after_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XS_WOCC && occ_s) |=> run_o);
  // R8
  run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !more_i) |=> !run_o);
  // R10
  eot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_irq |=> !eot_irq);
  // R11
  tmo_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_o) |-> !run_o);
endmodule

// File: rtl/drv_rd_rx.sv
module drv_rd_rx #(
  parameter int DW       = 16,
  parameter int SYNC_FF  = 2,
  parameter int TMO_CYC  = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic          occ_i,
  input  logic          sclk_i,
  input  logic          ebl_i,
  input  logic [DW-1:0] dat_i,
  input  logic          par_i,
  input  logic          more_i,
  output logic          run_o,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_perr,
  output logic          m_ovf,
  output logic          tmo_o,
  output logic          eot_irq
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, synced;
  logic sclk_d, ebl_d;
  logic sclk_fall, ebl_rise, ebl_fall;
  logic cap_en, clr;

  assign raw_in = {occ_i, ebl_i, sclk_i};

  for (genvar i = 0; i < NSYNC; i++) begin : g_sync
    bit_sync #(.STAGES(SYNC_FF)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in[i]), .q(synced[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ebl_d  <= 1'b0;
    end else begin
      sclk_d <= synced[0];
      ebl_d  <= synced[1];
    end
  end

  assign sclk_fall = sclk_d && !synced[0];
  assign ebl_rise  = !ebl_d && synced[1];
  assign ebl_fall  = ebl_d && !synced[1];

  xfer_ctl #(.TMO_CYC(TMO_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .occ_s(synced[2]),
    .ebl_rise(ebl_rise), .ebl_fall(ebl_fall), .word_seen(sclk_fall),
    .more_i(more_i), .run_o(run_o), .cap_en(cap_en), .clr(clr),
    .eot_irq(eot_irq), .tmo_o(tmo_o)
  );

  rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .strobe_fall(sclk_fall),
    .dat_i(dat_i), .par_i(par_i), .clr(clr), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .m_perr(m_perr), .m_ovf(m_ovf)
  );

  // R3
  no_word_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !m_valid) |=> !m_valid);
endmodule

// File: tb/sim_drv_rd_rx.sv
module sim_drv_rd_rx;
  localparam int DW  = 16;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_go = 0, occ_i = 0, sclk_i = 0, ebl_i = 0, par_i = 0, more_i = 0;
  logic m_ready = 0;
  logic [DW-1:0] dat_i = '0;
  logic run_o, m_valid, m_perr, m_ovf, tmo_o, eot_irq;
  logic [DW-1:0] m_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  drv_rd_rx #(.DW(DW), .SYNC_FF(2), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .occ_i(occ_i), .sclk_i(sclk_i),
    .ebl_i(ebl_i), .dat_i(dat_i), .par_i(par_i), .more_i(more_i), .run_o(run_o),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_perr(m_perr),
    .m_ovf(m_ovf), .tmo_o(tmo_o), .eot_irq(eot_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer(input bit more);
    more_i = more;
    cmd_go = 1; cyc(1); cmd_go = 0;
    occ_i = 1;
    begin
      int k = 0;
      while (!run_o && k < 6) begin cyc(1); k++; end
      chk(run_o && k <= 4, "R2 run after occ", k, 4);
    end
  endtask

  task automatic strobe(input logic [DW-1:0] d, input bit bad);
    dat_i = d;
    par_i = ~(^d) ^ bad;
    sclk_i = 1; cyc(4);
    sclk_i = 0; cyc(5);
  endtask

  task automatic take_word(input logic [DW-1:0] d, input bit perr, input string req);
    chk(m_valid, req, m_valid, 1);
    chk(m_data == d && m_perr == perr, req, {m_perr, m_data}, {perr, d});
    m_ready = 1; cyc(1); m_ready = 0;
    chk(!m_valid, {req, " consumed"}, m_valid, 0);
  endtask

  task automatic end_block(input bit expect_eot);
    int irq = 0;
    ebl_i = 1; cyc(6);
    ebl_i = 0;
    for (int i = 0; i < 8; i++) begin cyc(1); irq += eot_irq; end
    chk(irq == (expect_eot ? 1 : 0), "R10/R7 eot pulse count", irq, expect_eot ? 1 : 0);
  endtask

  task automatic t_reset();
    chk(!run_o && !m_valid && !m_ovf && !tmo_o && !eot_irq, "R1 reset state",
        {run_o, m_valid, m_ovf, tmo_o, eot_irq}, 0);
  endtask

  task automatic t_idle_strobe();
    strobe(16'h1234, 0);
    chk(!m_valid, "R3 strobe while idle", m_valid, 0);
  endtask

  task automatic t_basic();
    cmd_go = 1; cyc(1); cmd_go = 0; cyc(8);
    chk(!run_o, "R2 no run before occ", run_o, 0);
    occ_i = 1;
    begin
      int k = 0;
      while (!run_o && k < 6) begin cyc(1); k++; end
      chk(run_o && k <= 4, "R2 run after occ", k, 4);
    end
    more_i = 1;
    cmd_go = 1; cyc(1); cmd_go = 0;
    chk(run_o, "R2 cmd_go ignored when busy", run_o, 1);
    dat_i = 16'hA5A5; par_i = ~(^dat_i); sclk_i = 1; cyc(5);
    chk(!m_valid, "R3 rise does not capture", m_valid, 0);
    dat_i = 16'h0F01; par_i = ~(^dat_i);
    sclk_i = 0; cyc(5);
    take_word(16'h0F01, 0, "R3 capture at fall");
    strobe(16'h0003, 1);
    take_word(16'h0003, 1, "R4 bad parity flagged");
    strobe(16'h0007, 0);
    take_word(16'h0007, 0, "R4 good parity clean");
    more_i = 0;
    ebl_i = 1;
    begin
      int k = 0;
      while (run_o && k < 6) begin cyc(1); k++; end
      chk(!run_o && k <= 4, "R8 run drop after ebl", k, 4);
    end
    cyc(4); ebl_i = 0;
    begin
      int irq = 0;
      for (int i = 0; i < 8; i++) begin cyc(1); irq += eot_irq; end
      chk(irq == 1, "R10 single eot pulse", irq, 1);
    end
    occ_i = 0; cyc(4);
  endtask

  task automatic t_backpressure();
    begin_xfer(1);
    strobe(16'hBEEF, 0);
    cyc(3);
    chk(m_valid && m_data == 16'hBEEF, "R5 held under stall", m_data, 16'hBEEF);
    chk(!m_ovf, "R6 no overflow yet", m_ovf, 0);
    strobe(16'h1111, 0);
    chk(m_ovf, "R6 overflow set", m_ovf, 1);
    take_word(16'hBEEF, 0, "R6 held word kept");
    strobe(16'h2222, 1);
    take_word(16'h2222, 1, "R5 next word after drain");
    chk(m_ovf, "R6 overflow sticky", m_ovf, 1);
    more_i = 0; end_block(1); occ_i = 0; cyc(4);
    cmd_go = 1; cyc(1); cmd_go = 0; cyc(1);
    chk(!m_ovf, "R6 overflow cleared by command", m_ovf, 0);
    occ_i = 1; cyc(5); more_i = 0; cyc(2); end_block(1); occ_i = 0; cyc(4);
  endtask

  task automatic t_multiblock();
    begin_xfer(1);
    strobe(16'h0101, 0); take_word(16'h0101, 0, "R7 block one word");
    end_block(0);
    chk(run_o, "R7 run held across block", run_o, 1);
    strobe(16'h0202, 0); take_word(16'h0202, 0, "R7 block two word");
    more_i = 0; cyc(2);
    end_block(1);
    chk(!run_o, "R10 idle after transfer", run_o, 0);
    occ_i = 0; cyc(4);
  endtask

  task automatic t_early_drop();
    begin_xfer(1);
    strobe(16'h0ACE, 0); take_word(16'h0ACE, 0, "R9 word before drop");
    more_i = 0; cyc(2);
    chk(!run_o, "R9 run low before ebl", run_o, 0);
    strobe(16'h0BAD, 1); take_word(16'h0BAD, 1, "R9 word after drop");
    end_block(1);
    chk(!tmo_o, "R9 no error", tmo_o, 0);
    occ_i = 0; cyc(4);
  endtask

  task automatic t_timeouts();
    occ_i = 0; more_i = 1;
    cmd_go = 1; cyc(1); cmd_go = 0;
    cyc(TMO / 2);
    chk(!tmo_o, "R11 not early", tmo_o, 0);
    cyc(TMO);
    chk(tmo_o && !run_o, "R11 occ timeout", {tmo_o, run_o}, 2);
    occ_i = 1; cyc(6);
    chk(!run_o, "R11 idle after timeout", run_o, 0);
    begin_xfer(1);
    chk(!tmo_o, "R11 cleared by command", tmo_o, 0);
    cyc(TMO + 8);
    chk(tmo_o && !run_o, "R11 silent drive timeout", {tmo_o, run_o}, 2);
    occ_i = 0; more_i = 0; cyc(4);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1; cyc(2);
    t_idle_strobe();
    t_basic();
    t_backpressure();
    t_multiblock();
    t_early_drop();
    t_timeouts();
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule